// File: doc/BRIEF.md
# Coded-Order Coefficient Address Generator

This block walks a frame of stored quantized transform coefficients in the order an entropy coder must emit them. It produces the addresses for that walk and nothing else. The walk is nested as follows. The coefficient index is the outermost loop, running from the DC term up to index 63. Inside it come the three colour planes. Inside each plane the generator crosses the 32x32-pixel superblocks. Inside each superblock it visits the sixteen 8x8 blocks along a fixed Hilbert path.

Each step yields one tuple:

- the coefficient index
- the plane
- the superblock column and row
- the position along the Hilbert path
- a linear block address into a frame-sized coefficient store

Software sets the luma frame size in 8x8 blocks and pulses start. Chroma follows 4:2:0 subsampling. Tuples leave over a valid/ready handshake. The final tuple of the frame carries a last flag. Block positions that fall outside the plane in partial superblocks are skipped.

Coordinates use x to the right and y upward. Block row 0 is the bottom row of the picture.

Top module: `coded_order_addr_gen`

## Requirements
- R1: After reset, `busy` and `out_valid` are low.
- R2: A `start` pulse while idle, with `blk_w` and `blk_h` both nonzero, sets `busy` on the next cycle and latches the dimensions. A `start` seen while busy, or with a zero dimension, is ignored.
- R3: `coef` is the outermost loop and runs 0, 1, ... 63 in ascending order.
- R4: For each coefficient, planes appear in the order Y (`plane`=0), Cb (1), Cr (2).
  - The Y plane is `blk_w` x `blk_h` blocks.
  - Each chroma plane is ceil(`blk_w`/2) x ceil(`blk_h`/2) blocks.
- R5: Within a plane, `sb_y` ascends from 0, which is the bottom superblock row. Within a row, `sb_x` ascends from 0 at the left.
- R6: `hil_idx` k selects offset (hx,hy) from this table:

  | k | 0 | 1 | 2 | 3 | 4 | 5 | 6 | 7 | 8 | 9 | 10 | 11 | 12 | 13 | 14 | 15 |
  |---|---|---|---|---|---|---|---|---|---|---|----|----|----|----|----|----|
  | (hx,hy) | (0,0) | (0,1) | (1,1) | (1,0) | (2,0) | (3,0) | (3,1) | (2,1) | (2,2) | (3,2) | (3,3) | (2,3) | (1,3) | (1,2) | (0,2) | (0,3) |

  The block column is 4*`sb_x`+hx and the block row is 4*`sb_y`+hy. Within a superblock, tuples appear in ascending k.
- R7: A position whose block column or row lies outside the plane produces no tuple.
- R8: `blk_addr` = base + row*pw + col, where pw is the plane width in blocks.
  - The base is 0 for Y.
  - The base is W*H for Cb.
  - The base is W*H + CW*CH for Cr.
  - W and H are the luma dimensions; CW and CH are the chroma dimensions.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and every tuple field holds its value.
- R10: `out_last` is high only with the final tuple, which is coefficient 63 of the last Cr block. After that tuple is accepted, `busy` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame walk |
| blk_w | input | 10 | Luma width in 8x8 blocks |
| blk_h | input | 10 | Luma height in 8x8 blocks |
| out_ready | input | 1 | Consumer accepts the tuple |
| busy | output | 1 | A frame walk is in progress |
| out_valid | output | 1 | Tuple fields are valid |
| coef | output | 6 | Coefficient index |
| plane | output | 2 | Plane: 0 Y, 1 Cb, 2 Cr |
| sb_x | output | 10 | Superblock column |
| sb_y | output | 10 | Superblock row, 0 at bottom |
| hil_idx | output | 4 | Position along the Hilbert path |
| blk_addr | output | 19 | Linear block address |
| out_last | output | 1 | Final tuple of the frame |

## Verification
The hardest case to reach is the final tuple when the last superblock of the Cr plane is partial. The last flag must then land on an early Hilbert position, and the path positions after it are never visited. The stimulus reaches this case with odd and non-multiple-of-four luma sizes, chosen so that chroma rounding leaves one- to three-block fringes in both directions. A second difficult case is a start pulse that arrives mid-frame with different dimensions. The stimulus injects that pulse during a throttled-ready run and then checks that the remaining sequence is unchanged.

// File: rtl/coded_order_addr_gen.sv
module coded_order_addr_gen #(
  parameter int MAX_BW = 512,
  parameter int MAX_BH = 512
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [$clog2(MAX_BW+1)-1:0] blk_w,
  input  logic [$clog2(MAX_BH+1)-1:0] blk_h,
  input  logic                 out_ready,
  output logic                 busy,
  output logic                 out_valid,
  output logic [5:0]           coef,
  output logic [1:0]           plane,
  output logic [$clog2(MAX_BW+1)-1:0] sb_x,
  output logic [$clog2(MAX_BH+1)-1:0] sb_y,
  output logic [3:0]           hil_idx,
  output logic [$clog2(MAX_BW*MAX_BH + 2*((MAX_BW+1)/2)*((MAX_BH+1)/2) + 1)-1:0] blk_addr,
  output logic                 out_last
);
  localparam int WW = $clog2(MAX_BW+1);
  localparam int HW = $clog2(MAX_BH+1);
  localparam int AW = $clog2(MAX_BW*MAX_BH + 2*((MAX_BW+1)/2)*((MAX_BH+1)/2) + 1);

  function automatic logic [3:0] hil_xy(input logic [3:0] k);
    case (k)
      4'd0:  hil_xy = {2'd0, 2'd0};
      4'd1:  hil_xy = {2'd0, 2'd1};
      4'd2:  hil_xy = {2'd1, 2'd1};
      4'd3:  hil_xy = {2'd1, 2'd0};
      4'd4:  hil_xy = {2'd2, 2'd0};
      4'd5:  hil_xy = {2'd3, 2'd0};
      4'd6:  hil_xy = {2'd3, 2'd1};
      4'd7:  hil_xy = {2'd2, 2'd1};
      4'd8:  hil_xy = {2'd2, 2'd2};
      4'd9:  hil_xy = {2'd3, 2'd2};
      4'd10: hil_xy = {2'd3, 2'd3};
      4'd11: hil_xy = {2'd2, 2'd3};
      4'd12: hil_xy = {2'd1, 2'd3};
      4'd13: hil_xy = {2'd1, 2'd2};
      4'd14: hil_xy = {2'd0, 2'd2};
      default: hil_xy = {2'd0, 2'd3};
    endcase
  endfunction

  logic [WW-1:0] w_r, cw, pw, nsbx_m1;
  logic [HW-1:0] h_r, ch, ph, nsby_m1;
  logic [3:0]    hxy;
  logic [WW+1:0] col;
  logic [HW+1:0] row;
  logic [2:0]    rem_x, rem_y;
  logic [15:0]   tail_mask;
  logic          in_plane, last_sb, tail_empty, step, hil_end, sbx_end, sby_end;
  logic [AW-1:0] luma_sz, chroma_sz, base;

  assign cw = WW'((WW+1)'(w_r) + 1'b1 >> 1);
  assign ch = HW'((HW+1)'(h_r) + 1'b1 >> 1);
  assign pw = (plane == 2'd0) ? w_r : cw;
  assign ph = (plane == 2'd0) ? h_r : ch;
  assign nsbx_m1 = WW'(((WW+2)'(pw) + (WW+2)'(3)) >> 2) - WW'(1);
  assign nsby_m1 = HW'(((HW+2)'(ph) + (HW+2)'(3)) >> 2) - HW'(1);

  assign hxy = hil_xy(hil_idx);
  assign col = {sb_x, 2'b00} + (WW+2)'(hxy[3:2]);
  assign row = {sb_y, 2'b00} + (HW+2)'(hxy[1:0]);
  assign in_plane = (col < (WW+2)'(pw)) && (row < (HW+2)'(ph));

  assign rem_x = 3'((WW+2)'(pw) - {nsbx_m1, 2'b00});
  assign rem_y = 3'((HW+2)'(ph) - {nsby_m1, 2'b00});

  for (genvar k = 0; k < 16; k++) begin : g_tail
    localparam logic [3:0] KXY = hil_xy(4'(k));
    assign tail_mask[k] = (3'(KXY[3:2]) < rem_x) && (3'(KXY[1:0]) < rem_y);
  end

  assign hil_end    = (hil_idx == 4'd15);
  assign sbx_end    = (sb_x == nsbx_m1);
  assign sby_end    = (sb_y == nsby_m1);
  assign last_sb    = sbx_end && sby_end;
  assign tail_empty = ((tail_mask >> hil_idx) >> 1) == 16'd0;

  assign out_valid = busy && in_plane;
  assign out_last  = out_valid && (coef == 6'd63) && (plane == 2'd2) && last_sb && tail_empty;
  assign step      = busy && (!in_plane || out_ready);

  assign luma_sz   = AW'(w_r) * AW'(h_r);
  assign chroma_sz = AW'(cw) * AW'(ch);
  assign base      = (plane == 2'd0) ? '0 : (plane == 2'd1) ? luma_sz : luma_sz + chroma_sz;
  assign blk_addr  = base + AW'(row) * AW'(pw) + AW'(col);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      coef <= '0; plane <= '0; sb_x <= '0; sb_y <= '0; hil_idx <= '0;
      w_r <= '0; h_r <= '0;
    end else if (!busy) begin
      if (start && blk_w != '0 && blk_h != '0) begin
        busy <= 1'b1;
        w_r <= blk_w; h_r <= blk_h;
        coef <= '0; plane <= '0; sb_x <= '0; sb_y <= '0; hil_idx <= '0;
      end
    end else if (step) begin
      if (out_last) begin
        busy <= 1'b0;
      end else if (!hil_end) begin
        hil_idx <= hil_idx + 4'd1;
      end else begin
        hil_idx <= '0;
        if (!sbx_end) sb_x <= sb_x + WW'(1);
        else begin
          sb_x <= '0;
          if (!sby_end) sb_y <= sb_y + HW'(1);
          else begin
            sb_y <= '0;
            if (plane != 2'd2) plane <= plane + 2'd1;
            else begin
              plane <= '0;
              coef  <= coef + 6'd1;
            end
          end
        end
      end
    end
  end

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && blk_w != '0 && blk_h != '0) |=> busy);
  assert_coef_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (coef >= $past(coef)));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(coef) && $stable(plane) &&
      $stable(sb_x) && $stable(sb_y) && $stable(hil_idx) && $stable(blk_addr)));
  assert_last_tuple_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (out_valid && coef == 6'd63 && plane == 2'd2));
  assert_last_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_last && out_ready) |=> (!busy && !out_valid));
endmodule

// File: tb/coded_order_addr_gen_tb.sv
module coded_order_addr_gen_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, out_ready = 1'b0;
  logic [9:0] blk_w = '0, blk_h = '0;
  logic busy, out_valid, out_last;
  logic [5:0] coef;
  logic [1:0] plane;
  logic [9:0] sb_x, sb_y;
  logic [3:0] hil_idx;
  logic [18:0] blk_addr;
  int checks = 0, fails = 0, cycles = 0;

  always #5 clk = ~clk;

  coded_order_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_w(blk_w), .blk_h(blk_h),
    .out_ready(out_ready), .busy(busy), .out_valid(out_valid), .coef(coef),
    .plane(plane), .sb_x(sb_x), .sb_y(sb_y), .hil_idx(hil_idx),
    .blk_addr(blk_addr), .out_last(out_last));

  const int HX[16] = '{0,0,1,1,2,3,3,2,2,3,3,2,1,1,0,0};
  const int HY[16] = '{0,1,1,0,0,0,1,1,2,2,3,3,3,2,2,3};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_frame(input int w, input int h, input bit throttle, input bit inject);
    int cw = (w + 1) / 2, ch = (h + 1) / 2;
    int total = 64 * (w * h + 2 * cw * ch);
    int idx = 0;
    bit abort = 0;
    @(negedge clk);
    out_ready = 0; blk_w = 10'(w); blk_h = 10'(h); start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1'b1, "R2 busy after start", longint'(busy), 1);
    for (int c = 0; c < 64 && !abort; c++)
      for (int p = 0; p < 3 && !abort; p++) begin
        int pw = (p == 0) ? w : cw;
        int ph = (p == 0) ? h : ch;
        int base = (p == 0) ? 0 : (p == 1) ? w * h : w * h + cw * ch;
        for (int sy = 0; sy < (ph + 3) / 4 && !abort; sy++)
          for (int sx = 0; sx < (pw + 3) / 4 && !abort; sx++)
            for (int k = 0; k < 16 && !abort; k++) begin
              int bx = 4 * sx + HX[k], by = 4 * sy + HY[k];
              bit got = 0, hold = 0;
              int guard = 0;
              longint ha = 0;
              if (bx >= pw || by >= ph) continue;
              while (!got && !abort) begin
                bit rdy;
                @(negedge clk);
                rdy = throttle ? ($urandom_range(0, 3) != 0) : 1'b1;
                out_ready = rdy;
                if (inject && idx == 100) begin blk_w = 10'd9; blk_h = 10'd9; start = 1; end
                else start = 0;
                if (hold)
                  chk(out_valid && longint'(blk_addr) == ha, "R9 hold", longint'(blk_addr), ha);
                hold = 0;
                if (out_valid && rdy) begin
                  got = 1;
                  chk(int'(coef) == c, "R3 coef", longint'(coef), c);
                  chk(int'(plane) == p, "R4 plane", longint'(plane), p);
                  chk(int'(sb_x) == sx && int'(sb_y) == sy, "R5 superblock",
                      longint'(sb_y) * 1000 + longint'(sb_x), sy * 1000 + sx);
                  chk(int'(hil_idx) == k, "R6 hilbert", longint'(hil_idx), k);
                  chk(int'(blk_addr) == base + by * pw + bx, "R7 R8 address",
                      longint'(blk_addr), base + by * pw + bx);
                  chk(out_last == (idx == total - 1), "R10 last flag",
                      longint'(out_last), longint'(idx == total - 1));
                  idx++;
                end else if (out_valid) begin
                  hold = 1; ha = longint'(blk_addr);
                end
                guard++;
                if (guard > 100) begin
                  chk(0, "R7 stalled", 0, 1);
                  abort = 1;
                end
              end
            end
      end
    start = 0;
    @(negedge clk);
    out_ready = 0;
    chk(!busy && !out_valid, "R10 idle after frame", longint'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !out_valid, "R1 reset state", longint'(out_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !out_valid, "R1 idle after reset", longint'(busy), 0);
    blk_w = 10'd0; blk_h = 10'd4; start = 1;
    @(negedge clk);
    start = 0;
    repeat (2) @(negedge clk);
    chk(!busy && !out_valid, "R2 zero width ignored", longint'(busy), 0);
    run_frame(1, 1, 0, 0);
    run_frame(4, 4, 1, 0);
    run_frame(5, 3, 1, 1);
    run_frame(8, 6, 0, 0);
    run_frame(3, 9, 1, 0);
    run_frame(9, 2, 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule